// File: doc/BRIEF.md
# Read-Priority Write Buffer

This block sits between a cache and the next memory level. It holds outgoing write traffic so that the cache never waits on the downstream bus to accept a write. Both single store writes from a write-through cache and evicted dirty lines from a write-back cache use it. Each slot holds a line address and a full line of data. Writes leave the buffer in the order they arrived, and only when no read needs the bus.

Read requests from the cache pass straight through to the same downstream request port and take precedence over queued writes. A read whose line address equals the address of any write still in the buffer is held back. The buffer keeps draining in the meantime. The read is released once the matching entry has left, so it never fetches stale memory contents. The downstream port uses a valid/ready handshake. The occupancy and an empty indication are exported.

Top module: `wrq_top`

## Requirements
- R1: After synchronous reset the buffer is empty, `empty` is 1, `count` is 0 and `wr_ready` is 1.
- R2: While fewer than DEPTH (default 4) entries are held, `wr_ready` is 1 and a write with `wr_valid` high is taken in that same cycle, raising `count` by one at the next edge.
- R3: When DEPTH entries are held and no entry leaves in the cycle, `wr_ready` is 0, the offered write is not taken and `count` stays at DEPTH.
- R4: Buffered writes are offered downstream in arrival order with `mem_we` = 1, carrying the stored line address on `mem_addr` and the stored line on `mem_wdata`.
- R5: A read with `rd_valid` high whose address matches no buffered entry is offered downstream ahead of any buffered write, with `mem_we` = 0 and `mem_addr` = `rd_addr`; `rd_ready` equals `mem_ready` in that case and no write leaves.
- R6: A read whose address matches any buffered entry gets `rd_ready` = 0; the oldest write is offered instead, and the read is offered once no buffered entry matches.
- R7: An entry leaves only in a cycle where `mem_valid`, `mem_we` and `mem_ready` are all 1; while `mem_ready` stays 0 the offered write and `count` do not change.
- R8: With DEPTH entries held, a write and a downstream write handshake in the same cycle are both accepted (`wr_ready` = 1) and `count` stays at DEPTH.
- R9: `count` equals the number of held entries and `empty` is 1 exactly when it is 0.
- R10: With no entry held and `rd_valid` low, `mem_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write offered by the cache |
| wr_ready | output | 1 | Write taken this cycle |
| wr_addr | input | ADDR_W | Line address of the write |
| wr_data | input | DATA_W | Line data of the write |
| rd_valid | input | 1 | Read request from the cache |
| rd_ready | output | 1 | Read forwarded downstream this cycle |
| rd_addr | input | ADDR_W | Line address of the read |
| mem_valid | output | 1 | Downstream request present |
| mem_ready | input | 1 | Downstream accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Downstream line address |
| mem_wdata | output | DATA_W | Downstream line data for writes |
| empty | output | 1 | No entry held |
| count | output | CNT_W | Number of held entries |

## Verification
A corrupted pointer or slot-valid bit shows at the downstream port on the very next write offer. The wrong address or data appears on `mem_addr`/`mem_wdata`, or `count` and the issued sequence drift apart. A broken address compare shows in the same cycle the read is raised: `rd_ready` goes high while a matching write is still held, or stays low with no match. A wrong arbitration choice is visible in that same cycle on `mem_we`.

// File: rtl/wrq_pkg.sv
package wrq_pkg;

    localparam int unsigned WRQ_ADDR_W = 26;
    localparam int unsigned WRQ_DATA_W = 256;
    localparam int unsigned WRQ_DEPTH  = 4;

    // Owner of the downstream request port in a given cycle
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_sel_e;

    // Circular slot index advance
    function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/wrq_fifo.sv
module wrq_fifo
    import wrq_pkg::*;
#(
    parameter int unsigned ADDR_W = WRQ_ADDR_W,
    parameter int unsigned DATA_W = WRQ_DATA_W,
    parameter int unsigned DEPTH  = WRQ_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  occ,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  slot_vld_q;
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  occ_q;
    logic [DEPTH-1:0]  slot_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q   <= '0;
            rd_ptr_q   <= '0;
            occ_q      <= '0;
            slot_vld_q <= '0;
        end else begin
            // Clear before set: on a full swap both touch the same slot
            if (pop) begin
                slot_vld_q[rd_ptr_q] <= 1'b0;
                rd_ptr_q <= PTR_W'(wrap_inc(32'(rd_ptr_q), DEPTH));
            end
            if (push) begin
                slot_vld_q[wr_ptr_q] <= 1'b1;
                addr_q[wr_ptr_q]     <= push_addr;
                data_q[wr_ptr_q]     <= push_data;
                wr_ptr_q <= PTR_W'(wrap_inc(32'(wr_ptr_q), DEPTH));
            end
            unique case ({push, pop})
                2'b10:   occ_q <= occ_q + CNT_W'(1);
                2'b01:   occ_q <= occ_q - CNT_W'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end

    // One address comparator per slot, qualified by that slot's valid bit
    for (genvar g = 0; g < DEPTH; g++) begin : g_probe
        assign slot_hit[g] = slot_vld_q[g] && (addr_q[g] == probe_addr);
    end

    assign probe_hit = |slot_hit;
    assign head_addr = addr_q[rd_ptr_q];
    assign head_data = data_q[rd_ptr_q];
    assign occ       = occ_q;

endmodule

// File: rtl/wrq_arb.sv
module wrq_arb
    import wrq_pkg::*;
(
    input  logic     rd_valid,
    input  logic     rd_conflict,
    input  logic     q_empty,
    input  logic     mem_ready,
    output bus_sel_e sel,
    output logic     rd_grant,
    output logic     wr_pop
);

    always_comb begin
        sel = BUS_IDLE;
        if (rd_valid && !rd_conflict) begin
            sel = BUS_READ;
        end else if (!q_empty) begin
            sel = BUS_WRITE;
        end
    end

    assign rd_grant = (sel == BUS_READ)  && mem_ready;
    assign wr_pop   = (sel == BUS_WRITE) && mem_ready;

endmodule

// File: rtl/wrq_top.sv
module wrq_top
    import wrq_pkg::*;
#(
    parameter int unsigned ADDR_W = WRQ_ADDR_W,
    parameter int unsigned DATA_W = WRQ_DATA_W,
    parameter int unsigned DEPTH  = WRQ_DEPTH,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);

    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  occ;
    logic              rd_conflict;
    logic              q_empty;
    logic              q_full;
    logic              push;
    logic              pop;
    bus_sel_e          sel;

    assign q_empty  = (occ == '0);
    assign q_full   = (occ == CNT_W'(DEPTH));
    // A slot freed this cycle may be refilled in the same cycle
    assign wr_ready = !q_full || pop;
    assign push     = wr_valid && wr_ready;

    wrq_fifo #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_addr  (wr_addr),
        .push_data  (wr_data),
        .pop        (pop),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .occ        (occ),
        .probe_addr (rd_addr),
        .probe_hit  (rd_conflict)
    );

    wrq_arb u_arb (
        .rd_valid    (rd_valid),
        .rd_conflict (rd_conflict),
        .q_empty     (q_empty),
        .mem_ready   (mem_ready),
        .sel         (sel),
        .rd_grant    (rd_ready),
        .wr_pop      (pop)
    );

    assign mem_valid = (sel != BUS_IDLE);
    assign mem_we    = (sel == BUS_WRITE);
    assign mem_addr  = (sel == BUS_READ) ? rd_addr : head_addr;
    assign mem_wdata = head_data;
    assign empty     = q_empty;
    assign count     = occ;

endmodule

// File: rtl/wrq_checker.sv
module wrq_checker #(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              empty,
    input logic [CNT_W-1:0]  count
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) && !(mem_valid && mem_we && mem_ready) |-> !wr_ready);

    p_room_accept_r2: assert property (@(posedge clk) disable iff (rst)
        wr_valid && (count < CNT_W'(DEPTH)) |-> wr_ready);

    p_read_first_r5: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> mem_valid && !mem_we && (mem_addr == rd_addr) && mem_ready);

    p_pop_handshake_r7: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && mem_we && mem_ready) |=> count >= $past(count));

    p_empty_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        empty |-> !(mem_valid && mem_we));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        empty && !rd_valid |-> !mem_valid);

endmodule

bind wrq_top wrq_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/wrq_top_tb_top.sv
module wrq_top_tb_top;

    localparam int unsigned ADDR_W = 26;
    localparam int unsigned DATA_W = 256;
    localparam int unsigned DEPTH  = 4;
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_valid = 1'b0;
    logic              rd_ready;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              mem_valid;
    logic              mem_ready = 1'b0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              empty;
    logic [CNT_W-1:0]  count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 4 ns period

    wrq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .empty(empty), .count(count)
    );

    function automatic logic [DATA_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return {(DATA_W/32){32'hC0DE_0000 ^ 32'(a)}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Offer one write for one cycle while the downstream port is stalled
    task automatic push_one(input logic [ADDR_W-1:0] a);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = line_of(a);
        #1;
        chk(wr_ready == 1'b1, "R2 wr_ready with room", 64'(wr_ready), 64'd1);
        step();
        wr_valid = 1'b0;
    endtask

    // Expect the head write on the port, then let it go
    task automatic drain_one(input logic [ADDR_W-1:0] a);
        mem_ready = 1'b1;
        #1;
        chk(mem_valid && mem_we && (mem_addr == a), "R4 write order addr", 64'(mem_addr), 64'(a));
        chk(mem_wdata == line_of(a), "R4 write data", mem_wdata[63:0], line_of(a) ~^ ~line_of(a) ? line_of(a)[63:0] : 64'd0);
        step();
        mem_ready = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        #1;
        chk(empty == 1'b1, "R1 empty after reset", 64'(empty), 64'd1);
        chk(count == '0, "R1 count after reset", 64'(count), 64'd0);
        chk(wr_ready == 1'b1, "R1 wr_ready after reset", 64'(wr_ready), 64'd1);
        chk(mem_valid == 1'b0, "R10 idle port", 64'(mem_valid), 64'd0);
    endtask

    task automatic t_fill_and_stall();
        mem_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            push_one(ADDR_W'(26'h100 + i));
            #1;
            chk(count == CNT_W'(i + 1), "R9 count while filling", 64'(count), 64'(i + 1));
        end
        chk(empty == 1'b0, "R9 not empty", 64'(empty), 64'd0);
        wr_valid = 1'b1;
        wr_addr  = 26'h1FF;
        wr_data  = line_of(26'h1FF);
        #1;
        chk(wr_ready == 1'b0, "R3 stall when full", 64'(wr_ready), 64'd0);
        step();
        wr_valid = 1'b0;
        #1;
        chk(count == CNT_W'(4), "R3 count held at depth", 64'(count), 64'd4);
        chk(mem_valid && mem_we && (mem_addr == 26'h100), "R4 head offered", 64'(mem_addr), 64'h100);
    endtask

    task automatic t_full_swap();
        wr_valid  = 1'b1;
        wr_addr   = 26'h104;
        wr_data   = line_of(26'h104);
        mem_ready = 1'b1;
        #1;
        chk(wr_ready == 1'b1, "R8 accept write while full and popping", 64'(wr_ready), 64'd1);
        chk(mem_addr == 26'h100, "R4 first out", 64'(mem_addr), 64'h100);
        step();
        wr_valid  = 1'b0;
        mem_ready = 1'b0;
        #1;
        chk(count == CNT_W'(4), "R8 count unchanged on swap", 64'(count), 64'd4);
        for (int i = 1; i <= 4; i++) drain_one(ADDR_W'(26'h100 + i));
        #1;
        chk(empty == 1'b1, "R9 empty after drain", 64'(empty), 64'd1);
        chk(mem_valid == 1'b0, "R10 quiet after drain", 64'(mem_valid), 64'd0);
    endtask

    task automatic t_hold();
        mem_ready = 1'b0;
        push_one(26'h2A0);
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(mem_valid && mem_we && (mem_addr == 26'h2A0), "R7 offer held", 64'(mem_addr), 64'h2A0);
            chk(count == CNT_W'(1), "R7 no pop without ready", 64'(count), 64'd1);
            step();
        end
        drain_one(26'h2A0);
        #1;
        chk(empty == 1'b1, "R7 pop on handshake", 64'(empty), 64'd1);
    endtask

    task automatic t_read_priority();
        push_one(26'h300);
        push_one(26'h301);
        rd_valid  = 1'b1;
        rd_addr   = 26'h3F0;
        mem_ready = 1'b0;
        #1;
        chk(rd_ready == 1'b0, "R5 rd_ready follows mem_ready low", 64'(rd_ready), 64'd0);
        chk(mem_valid && !mem_we && (mem_addr == 26'h3F0), "R5 read offered first", 64'(mem_addr), 64'h3F0);
        mem_ready = 1'b1;
        #1;
        chk(rd_ready == 1'b1, "R5 read granted", 64'(rd_ready), 64'd1);
        step();
        rd_valid  = 1'b0;
        mem_ready = 1'b0;
        #1;
        chk(count == CNT_W'(2), "R5 writes wait behind read", 64'(count), 64'd2);
        drain_one(26'h300);
        drain_one(26'h301);
        #1;
        chk(empty == 1'b1, "R5 drained after read", 64'(empty), 64'd1);
    endtask

    task automatic t_conflict();
        push_one(26'h400);
        push_one(26'h401);
        rd_valid  = 1'b1;
        rd_addr   = 26'h401;
        mem_ready = 1'b1;
        #1;
        chk(rd_ready == 1'b0, "R6 matching read held", 64'(rd_ready), 64'd0);
        chk(mem_we && (mem_addr == 26'h400), "R6 oldest write goes", 64'(mem_addr), 64'h400);
        step();
        #1;
        chk(rd_ready == 1'b0, "R6 still held on younger match", 64'(rd_ready), 64'd0);
        chk(mem_we && (mem_addr == 26'h401), "R6 matching write goes", 64'(mem_addr), 64'h401);
        step();
        #1;
        chk(rd_ready && !mem_we && (mem_addr == 26'h401), "R6 read released", 64'(mem_addr), 64'h401);
        step();
        rd_valid  = 1'b0;
        mem_ready = 1'b0;
        #1;
        chk(empty == 1'b1, "R6 buffer empty", 64'(empty), 64'd1);
    endtask

    initial begin
        t_reset();
        t_fill_and_stall();
        t_full_swap();
        t_hold();
        t_read_priority();
        t_conflict();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule